// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Syndrome

This block runs one address translation at a time for a 32-bit processor with segmented, hashed-page memory management. A request carries the effective address, the access kind (load, store or instruction fetch), the operation class used by direct-store segments, and the relocation and privilege state bits. The sequencer steps through a fixed order of checks. It checks for a real-mode bypass first, then asks an external block-range matcher. If the matcher misses, it reads the segment register that the top four address bits select. That register may be a direct-store segment or carry the no-execute mark. Otherwise the sequencer asks an external page walker for the page entry and checks the access rights. The outcome is either a page-aligned real address with read/write/execute rights, or an exception with its class, error code, data syndrome word and fault address.

The block matcher and the page walker are separate units. Each is reached through a one-cycle request strobe followed by a done strobe carrying the response. The sequencer accepts a new request only while idle, and it ends every request with exactly one completion pulse.

Top module: `tseq_top`

## Requirements
- R1: When a fetch arrives with instruction relocation off, or a load or store arrives with data relocation off, the result is the effective address with its low 12 bits cleared and rights 3'b111 (bit0 read, bit1 write, bit2 execute). No block-match request is issued.
- R2: With relocation on, the block matcher is asked first. On a hit the result is the matcher's real address with the low 12 bits cleared and the matcher's rights, and no walk is started. If the hit's rights lack the needed bit (read for load, write for store, execute for fetch), the request raises a rights fault.
- R3: On a block miss, the segment register is taken from `seg_regs` slice number `ea[31:28]`. Its bits 23:0 are sent to the walker as the virtual segment id, together with the effective address.
- R4: The access key is 1 when segment bit 29 is set in problem state (`msr_pr`=1) or segment bit 30 is set in supervisor state. Otherwise it is 0. With key 0, pp=3 gives read only and other pp values give read and write. With key 1, pp=0 gives nothing, pp=2 gives read and write, and pp=1 or 3 give read only. Execute equals read unless segment bit 28 (no-execute) is set.
- R5: A fetch from a segment with bit 31 clear and bit 28 set raises an instruction fault with code 0x10000000, without any walk request.
- R6: A segment with bit 31 set and bits 28:20 equal to 0x07F maps the access to real address {seg[3:0], ea[27:12], 12'b0} with rights 3'b111, for every access kind.
- R7: In any other segment with bit 31 set, a fetch raises an instruction fault with code 0x10000000. For data accesses the result depends on `req_op`. Floating point (1) raises an alignment exception with code 0x00000001. Reserved (2) raises a data fault with syndrome 0x04000000, or 0x06000000 for a store. Cache operation (3) completes with the aligned effective address and rights 0. Integer (0) completes with the aligned effective address and rights 3'b011 when the key is 0 for a load or 1 for a store, and raises a rights fault otherwise.
- R8: Fetch faults use class 0 (instruction) with error code 0x40000000 when the walker finds no entry and 0x08000000 for a rights fault. Syndrome and fault address are 0.
- R9: Data faults use class 1 with error code 0 and the effective address as the fault address. The syndrome is 0x40000000 when no entry is found and 0x08000000 for a rights fault, with 0x02000000 added for a store. Class 2 marks the alignment exception, which also reports the fault address.
- R10: Every accepted request produces exactly one cycle with either `res_valid` or `exc_valid` high, never both. `req_ready` is low from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_op | input | 2 | Operation class for direct-store segments |
| msr_ir | input | 1 | Instruction relocation enable |
| msr_dr | input | 1 | Data relocation enable |
| msr_pr | input | 1 | Problem (user) state |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, slice i at bits 32*i+31:32*i |
| blk_req | output | 1 | Block-match request strobe |
| blk_ea | output | 32 | Address for the block matcher (held for the whole request) |
| blk_kind | output | 2 | Access kind for the block matcher |
| blk_done | input | 1 | Block matcher response strobe |
| blk_hit | input | 1 | Block range matched |
| blk_raddr | input | 32 | Real address from the block matcher |
| blk_rights | input | 3 | Rights from the block matcher |
| walk_req | output | 1 | Page-walk request strobe |
| walk_vsid | output | 24 | Virtual segment id for the walk |
| walk_ea | output | 32 | Effective address for the walk |
| walk_done | input | 1 | Walker response strobe |
| walk_found | input | 1 | Matching page entry found |
| walk_pp | input | 2 | Page protection field of the entry |
| walk_rpn | input | 20 | Real page number of the entry |
| res_valid | output | 1 | Translation result pulse |
| res_raddr | output | 32 | Page-aligned real address |
| res_rights | output | 3 | Granted rights (bit0 read, bit1 write, bit2 execute) |
| exc_valid | output | 1 | Exception pulse |
| exc_class | output | 2 | 0 instruction, 1 data, 2 alignment |
| exc_code | output | 32 | Error code |
| exc_dsisr | output | 32 | Data fault syndrome |
| exc_dar | output | 32 | Fault address |

## Verification
The block-matcher response and the walker response can arrive in the same cycle, because both strobes are inputs that the sequencer does not gate at its edge. The bench provokes this by having its walker model also pulse `blk_done` with a hit, carrying a different address and full rights, in the cycle it returns the page entry. The completion must carry the walker's page number and the rights table value, and the stray hit must be ignored. The bench also sweeps every access kind, privilege state, key bit pair and pp value, all eight block rights values, every direct-store operation class and all sixteen segments. It compares each outcome against values it computes from the rules above.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] OP_INT   = 2'd0;
  localparam logic [1:0] OP_FP    = 2'd1;
  localparam logic [1:0] OP_RSV   = 2'd2;
  localparam logic [1:0] OP_CACHE = 2'd3;

  localparam logic [1:0] EXC_ISI   = 2'd0;
  localparam logic [1:0] EXC_DSI   = 2'd1;
  localparam logic [1:0] EXC_ALIGN = 2'd2;

  localparam logic [31:0] CODE_NOTFOUND = 32'h4000_0000;
  localparam logic [31:0] CODE_RIGHTS   = 32'h0800_0000;
  localparam logic [31:0] CODE_NOEXEC   = 32'h1000_0000;
  localparam logic [31:0] SYN_RESERVED  = 32'h0400_0000;
  localparam logic [31:0] SYN_STORE     = 32'h0200_0000;
  localparam logic [31:0] ALIGN_FP_CODE = 32'h0000_0001;

  typedef enum logic [1:0] {
    F_NOTFOUND = 2'd0,
    F_RIGHTS   = 2'd1,
    F_NOEXEC   = 2'd2,
    F_DSTORE   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DISP  = 3'd1,
    S_BLKW  = 3'd2,
    S_SEG   = 3'd3,
    S_WALKW = 3'd4
  } state_e;
endpackage

// File: rtl/tseq_pp_rights.sv
module tseq_pp_rights (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       noexec,
  output logic [2:0] rights
);
  logic rd, wr;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    rights = {rd & ~noexec, wr, rd};
  end
endmodule

// File: rtl/tseq_syndrome.sv
module tseq_syndrome
  import tseq_pkg::*;
(
  input  fault_e      fault,
  input  logic [1:0]  kind,
  input  logic [1:0]  op,
  output logic [1:0]  cls,
  output logic [31:0] code,
  output logic [31:0] dsisr
);
  logic [31:0] st_bit;

  always_comb begin
    st_bit = (kind == KIND_STORE) ? SYN_STORE : 32'h0;
    cls    = EXC_DSI;
    code   = 32'h0;
    dsisr  = 32'h0;
    if (kind == KIND_FETCH) begin
      cls = EXC_ISI;
      unique case (fault)
        F_NOTFOUND: code = CODE_NOTFOUND;
        F_RIGHTS:   code = CODE_RIGHTS;
        default:    code = CODE_NOEXEC;
      endcase
    end else begin
      unique case (fault)
        F_NOTFOUND: dsisr = CODE_NOTFOUND | st_bit;
        F_RIGHTS:   dsisr = CODE_RIGHTS | st_bit;
        F_DSTORE: begin
          if (op == OP_FP) begin
            cls  = EXC_ALIGN;
            code = ALIGN_FP_CODE;
          end else begin
            dsisr = SYN_RESERVED | st_bit;
          end
        end
        default: dsisr = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          PAGE_BITS   = 12,
  parameter int          NSEG        = 16,
  parameter int          SEG_W       = 32,
  parameter int          VSID_W      = 24,
  parameter logic [8:0]  FORCED_UNIT = 9'h07F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_ea,
  input  logic [1:0]               req_kind,
  input  logic [1:0]               req_op,
  input  logic                     msr_ir,
  input  logic                     msr_dr,
  input  logic                     msr_pr,
  input  logic [NSEG*SEG_W-1:0]    seg_regs,
  output logic                     blk_req,
  output logic [AW-1:0]            blk_ea,
  output logic [1:0]               blk_kind,
  input  logic                     blk_done,
  input  logic                     blk_hit,
  input  logic [AW-1:0]            blk_raddr,
  input  logic [2:0]               blk_rights,
  output logic                     walk_req,
  output logic [VSID_W-1:0]        walk_vsid,
  output logic [AW-1:0]            walk_ea,
  input  logic                     walk_done,
  input  logic                     walk_found,
  input  logic [1:0]               walk_pp,
  input  logic [AW-PAGE_BITS-1:0]  walk_rpn,
  output logic                     res_valid,
  output logic [AW-1:0]            res_raddr,
  output logic [2:0]               res_rights,
  output logic                     exc_valid,
  output logic [1:0]               exc_class,
  output logic [31:0]              exc_code,
  output logic [31:0]              exc_dsisr,
  output logic [31:0]              exc_dar
);
  localparam int SEL_W = $clog2(NSEG);
  localparam int SEG_OFF_W = AW - SEL_W;
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  state_e            state, state_nx;
  logic [AW-1:0]     ea_q;
  logic [1:0]        kind_q, op_q;
  logic              ir_q, dr_q, pr_q, key_q, nx_q;
  logic              real_mode, need_ok_blk, need_ok_walk;
  logic [SEG_W-1:0]  sr;
  logic              sr_t, sr_ks, sr_kp, sr_nx, seg_key, launch;
  logic [8:0]        sr_unit;
  logic [2:0]        walk_rights, need_mask;
  logic              fin_res, fin_exc;
  logic [AW-1:0]     fin_raddr;
  logic [2:0]        fin_rights;
  fault_e            fin_fault;
  logic [1:0]        syn_cls;
  logic [31:0]       syn_code, syn_dsisr;

  assign req_ready = (state == S_IDLE);
  assign blk_ea    = ea_q;
  assign blk_kind  = kind_q;
  assign walk_ea   = ea_q;
  assign real_mode = (kind_q == KIND_FETCH) ? !ir_q : !dr_q;
  assign need_mask = (kind_q == KIND_FETCH) ? 3'b100 :
                     (kind_q == KIND_STORE) ? 3'b010 : 3'b001;

  // segment decode
  assign sr      = seg_regs[ea_q[AW-1 -: SEL_W]*SEG_W +: SEG_W];
  assign sr_t    = sr[31];
  assign sr_ks   = sr[30];
  assign sr_kp   = sr[29];
  assign sr_nx   = sr[28];
  assign sr_unit = sr[28:20];
  assign seg_key = (sr_kp & pr_q) | (sr_ks & ~pr_q);
  assign walk_vsid = sr[VSID_W-1:0];

  tseq_pp_rights u_rights (
    .key(key_q), .pp(walk_pp), .noexec(nx_q), .rights(walk_rights)
  );
  assign need_ok_blk  = |(blk_rights & need_mask);
  assign need_ok_walk = |(walk_rights & need_mask);

  tseq_syndrome u_syn (
    .fault(fin_fault), .kind(kind_q), .op(op_q),
    .cls(syn_cls), .code(syn_code), .dsisr(syn_dsisr)
  );

  // next-state and completion selection
  always_comb begin
    state_nx   = state;
    fin_res    = 1'b0;
    fin_exc    = 1'b0;
    fin_raddr  = ea_q & PAGE_MASK;
    fin_rights = 3'b000;
    fin_fault  = F_RIGHTS;
    blk_req    = 1'b0;
    launch     = 1'b0;
    unique case (state)
      S_IDLE: if (req_valid) state_nx = S_DISP;
      S_DISP: begin
        if (real_mode) begin
          fin_res = 1'b1; fin_rights = 3'b111; state_nx = S_IDLE;
        end else begin
          blk_req = 1'b1; state_nx = S_BLKW;
        end
      end
      S_BLKW: if (blk_done) begin
        if (!blk_hit) state_nx = S_SEG;
        else begin
          state_nx   = S_IDLE;
          fin_res    = need_ok_blk;
          fin_exc    = !need_ok_blk;
          fin_raddr  = blk_raddr & PAGE_MASK;
          fin_rights = blk_rights;
        end
      end
      S_SEG: begin
        state_nx = S_IDLE;
        if (sr_t) begin
          if (sr_unit == FORCED_UNIT) begin
            fin_res    = 1'b1;
            fin_rights = 3'b111;
            fin_raddr  = {sr[SEL_W-1:0], ea_q[SEG_OFF_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
          end else if (kind_q == KIND_FETCH || op_q == OP_FP || op_q == OP_RSV) begin
            fin_exc = 1'b1; fin_fault = F_DSTORE;
          end else if (op_q == OP_CACHE) begin
            fin_res = 1'b1;
          end else begin
            fin_res    = (kind_q == KIND_STORE) ? seg_key : !seg_key;
            fin_exc    = !fin_res;
            fin_rights = 3'b011;
          end
        end else if (sr_nx && kind_q == KIND_FETCH) begin
          fin_exc = 1'b1; fin_fault = F_NOEXEC;
        end else begin
          launch = 1'b1; state_nx = S_WALKW;
        end
      end
      S_WALKW: if (walk_done) begin
        state_nx   = S_IDLE;
        fin_raddr  = {walk_rpn, {PAGE_BITS{1'b0}}};
        fin_rights = walk_rights;
        fin_res    = walk_found && need_ok_walk;
        fin_exc    = !fin_res;
        fin_fault  = walk_found ? F_RIGHTS : F_NOTFOUND;
      end
      default: state_nx = S_IDLE;
    endcase
  end
  assign walk_req = launch;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ea_q <= '0; kind_q <= '0; op_q <= '0;
      ir_q <= 1'b0; dr_q <= 1'b0; pr_q <= 1'b0; key_q <= 1'b0; nx_q <= 1'b0;
      res_valid <= 1'b0; res_raddr <= '0; res_rights <= '0;
      exc_valid <= 1'b0; exc_class <= '0; exc_code <= '0;
      exc_dsisr <= '0; exc_dar <= '0;
    end else begin
      state     <= state_nx;
      res_valid <= fin_res;
      exc_valid <= fin_exc;
      if (state == S_IDLE && req_valid) begin
        ea_q <= req_ea; kind_q <= req_kind; op_q <= req_op;
        ir_q <= msr_ir; dr_q <= msr_dr; pr_q <= msr_pr;
      end
      if (launch) begin
        key_q <= seg_key;
        nx_q  <= sr_nx;
      end
      if (fin_res) begin
        res_raddr  <= fin_raddr;
        res_rights <= fin_rights;
      end
      if (fin_exc) begin
        exc_class <= syn_cls;
        exc_code  <= syn_code;
        exc_dsisr <= syn_dsisr;
        exc_dar   <= (syn_cls == EXC_ISI) ? 32'h0 : ea_q;
      end
    end
  end

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && exc_valid));
  // R10
  busy_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready && !res_valid && !exc_valid);
  // R2
  blk_hit_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLKW && blk_done && blk_hit) |=> (res_valid || exc_valid) && !walk_req);
  // R1
  realmode_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DISP && real_mode) |=> res_valid && res_rights == 3'b111);
  // R9
  data_dar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_class != EXC_ISI) |-> exc_dar == blk_ea);
  // R5
  nx_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !(blk_kind == KIND_FETCH && sr_nx));
endmodule

// File: tb/tseq_top_tb.sv
module tseq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [31:0] req_ea = 0;
  logic [1:0]  req_kind = 0, req_op = 0;
  logic        msr_ir = 0, msr_dr = 0, msr_pr = 0;
  logic [31:0] segs [16];
  logic [511:0] seg_regs;
  logic        blk_req, blk_done = 0, blk_hit = 0;
  logic [31:0] blk_ea, blk_raddr = 0;
  logic [1:0]  blk_kind;
  logic [2:0]  blk_rights = 0;
  logic        walk_req, walk_done = 0, walk_found = 0;
  logic [23:0] walk_vsid;
  logic [31:0] walk_ea;
  logic [1:0]  walk_pp = 0;
  logic [19:0] walk_rpn = 0;
  logic        res_valid, exc_valid;
  logic [31:0] res_raddr, exc_code, exc_dsisr, exc_dar;
  logic [2:0]  res_rights;
  logic [1:0]  exc_class;

  always_comb for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = segs[i];

  tseq_top u_dut (.*);

  int checks = 0, fails = 0;
  int blk_seen = 0, walk_seen = 0;
  logic        b_hit = 0, w_found = 0, stray = 0;
  logic [31:0] b_raddr = 0;
  logic [2:0]  b_rights = 0;
  logic [1:0]  w_pp = 0;
  logic [19:0] w_rpn = 0;
  logic [23:0] cap_vsid;
  logic [31:0] cap_ea;
  logic        g_res, g_exc;
  logic [31:0] g_raddr, g_code, g_dsisr, g_dar;
  logic [2:0]  g_rights;
  logic [1:0]  g_cls;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // block matcher model
  initial forever begin
    @(negedge clk);
    if (blk_req) begin
      blk_seen++;
      @(negedge clk);
      blk_done = 1; blk_hit = b_hit; blk_raddr = b_raddr; blk_rights = b_rights;
      @(negedge clk);
      blk_done = 0;
    end
  end

  // page walker model
  initial forever begin
    @(negedge clk);
    if (walk_req) begin
      walk_seen++; cap_vsid = walk_vsid; cap_ea = walk_ea;
      repeat (2) @(negedge clk);
      walk_done = 1; walk_found = w_found; walk_pp = w_pp; walk_rpn = w_rpn;
      if (stray) begin
        blk_done = 1; blk_hit = 1; blk_raddr = 32'hDEAD_B000; blk_rights = 3'b111;
      end
      @(negedge clk);
      walk_done = 0; blk_done = 0;
    end
  end

  task automatic run(input logic [31:0] ea, input logic [1:0] kind, input logic [1:0] op,
                     input logic ir, input logic dr, input logic pr);
    int n = 0;
    @(negedge clk);
    req_ea = ea; req_kind = kind; req_op = op;
    msr_ir = ir; msr_dr = dr; msr_pr = pr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 ready low while busy", {31'b0, req_ready}, 32'd0);
    while (!(res_valid || exc_valid) && n < 100) begin
      @(negedge clk); n++;
    end
    g_res = res_valid; g_exc = exc_valid; g_raddr = res_raddr; g_rights = res_rights;
    g_cls = exc_class; g_code = exc_code; g_dsisr = exc_dsisr; g_dar = exc_dar;
    chk("R10 single outcome", {30'b0, g_res, g_exc} == 2'b01 || {g_res, g_exc} == 2'b10, 32'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", {30'b0, res_valid, exc_valid}, 32'd0);
  endtask

  function automatic logic [2:0] pp_exp(input logic key, input logic [1:0] pp, input logic nx);
    logic r, w;
    r = key ? (pp != 0) : 1'b1;
    w = key ? (pp == 2) : (pp != 3);
    return {r & !nx, w, r};
  endfunction

  function automatic logic need_ok(input logic [2:0] rt, input logic [1:0] kind);
    return kind == 2 ? rt[2] : kind == 1 ? rt[1] : rt[0];
  endfunction

  task automatic expect_fault(input string tag, input logic [1:0] kind, input logic [31:0] base, input logic [31:0] ea);
    chk({tag, " exc"}, {31'b0, g_exc}, 32'd1);
    if (kind == 2) begin
      chk({tag, " R8 class"}, {30'b0, g_cls}, 32'd0);
      chk({tag, " R8 code"}, g_code, base);
    end else begin
      chk({tag, " R9 class"}, {30'b0, g_cls}, 32'd1);
      chk({tag, " R9 dsisr"}, g_dsisr, base | (kind == 1 ? 32'h0200_0000 : 32'h0));
      chk({tag, " R9 dar"}, g_dar, ea);
    end
  endtask

  task automatic expect_res(input string tag, input logic [31:0] ra, input logic [2:0] rt);
    chk({tag, " res"}, {31'b0, g_res}, 32'd1);
    chk({tag, " raddr"}, g_raddr, ra);
    chk({tag, " rights"}, {29'b0, g_rights}, {29'b0, rt});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int sb, sw;
    logic [31:0] ea;
    logic key, ok;
    for (int i = 0; i < 16; i++) segs[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset res_valid", {31'b0, res_valid}, 0);
    chk("reset exc_valid", {31'b0, exc_valid}, 0);
    chk("reset ready", {31'b0, req_ready}, 1);

    // R1 real mode and R2 block hits over relocation bits
    b_hit = 1; b_raddr = 32'h1234_5ABC; b_rights = 3'b111;
    for (int k = 0; k < 3; k++)
      for (int ir = 0; ir < 2; ir++)
        for (int dr = 0; dr < 2; dr++) begin
          sb = blk_seen;
          run(32'hCAFE_1357, k[1:0], 0, ir[0], dr[0], 0);
          if ((k == 2) ? ir == 0 : dr == 0) begin
            expect_res("R1 bypass", 32'hCAFE_1000, 3'b111);
            chk("R1 no block req", blk_seen - sb, 0);
          end else expect_res("R2 block hit", 32'h1234_5000, 3'b111);
        end

    // R2 block rights sweep
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 8; r++) begin
        b_rights = r[2:0]; sw = walk_seen;
        run(32'h0040_0010, k[1:0], 0, 1, 1, 0);
        chk("R2 no walk on hit", walk_seen - sw, 0);
        if (need_ok(r[2:0], k[1:0])) expect_res("R2 block", 32'h1234_5000, r[2:0]);
        else expect_fault("R2 block rights", k[1:0], 32'h0800_0000, 32'h0040_0010);
      end

    // R4 key and pp sweep through the walker
    b_hit = 0; w_found = 1; w_rpn = 20'hABCDE;
    for (int k = 0; k < 3; k++)
      for (int pr = 0; pr < 2; pr++)
        for (int ks = 0; ks < 2; ks++)
          for (int kp = 0; kp < 2; kp++)
            for (int pp = 0; pp < 4; pp++) begin
              segs[5] = {1'b0, ks[0], kp[0], 5'b0, 24'h00A5A5};
              w_pp = pp[1:0];
              key = (kp[0] & pr[0]) | (ks[0] & !pr[0]);
              run(32'h5123_4567, k[1:0], 0, 1, 1, pr[0]);
              if (need_ok(pp_exp(key, pp[1:0], 0), k[1:0]))
                expect_res("R4 walk", 32'hABCD_E000, pp_exp(key, pp[1:0], 0));
              else expect_fault("R4 rights", k[1:0], 32'h0800_0000, 32'h5123_4567);
            end

    // R8 R9 not found
    w_found = 0;
    for (int k = 0; k < 3; k++) begin
      run(32'h5000_0ABC, k[1:0], 0, 1, 1, 0);
      expect_fault("not found", k[1:0], 32'h4000_0000, 32'h5000_0ABC);
    end
    w_found = 1;

    // R5 no-execute segment
    segs[7] = 32'h1000_0777;
    sw = walk_seen;
    run(32'h7000_2000, 2, 0, 1, 1, 0);
    expect_fault("R5 nx fetch", 2, 32'h1000_0000, 0);
    chk("R5 no walk", walk_seen - sw, 0);
    w_pp = 2;
    run(32'h7000_2000, 0, 0, 1, 1, 0);
    expect_res("R5 nx load walks", 32'hABCD_E000, pp_exp(0, 2, 1));

    // R3 segment select
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 16; i++) segs[i] = {8'h0, 4'h3, i[3:0], 16'h1000 + i[15:0]};
      ea = {s[3:0], 28'h0ACE_123};
      run(ea, 0, 0, 1, 1, 0);
      chk("R3 vsid", {8'h0, cap_vsid}, {8'h0, 4'h3, s[3:0], 16'h1000 + s[15:0]});
      chk("R3 walk ea", cap_ea, ea);
    end

    // R6 forced direct-store
    segs[9] = {1'b1, 2'b11, 9'h07F, 16'h0, 4'hA};
    for (int k = 0; k < 3; k++) begin
      run(32'h9876_5432, k[1:0], 2, 1, 1, 1);
      expect_res("R6 forced", 32'hA876_5000, 3'b111);
    end

    // R7 other direct-store segments
    for (int pr = 0; pr < 2; pr++)
      for (int ks = 0; ks < 2; ks++)
        for (int kp = 0; kp < 2; kp++) begin
          segs[3] = {1'b1, ks[0], kp[0], 9'h010, 16'h0, 4'h0};
          key = (kp[0] & pr[0]) | (ks[0] & !pr[0]);
          run(32'h3000_5678, 2, 0, 1, 1, pr[0]);
          expect_fault("R7 ds fetch", 2, 32'h1000_0000, 0);
          for (int k = 0; k < 2; k++)
            for (int op = 0; op < 4; op++) begin
              run(32'h3000_5678, k[1:0], op[1:0], 1, 1, pr[0]);
              if (op == 1) begin
                chk("R7 fp class", {30'b0, g_cls}, 2);
                chk("R7 fp code", g_code, 1);
                chk("R7 fp dar", g_dar, 32'h3000_5678);
              end else if (op == 2) expect_fault("R7 reserved", k[1:0], 32'h0400_0000, 32'h3000_5678);
              else if (op == 3) expect_res("R7 cache", 32'h3000_5000, 3'b000);
              else begin
                ok = (k == 1) ? key : !key;
                if (ok) expect_res("R7 int", 32'h3000_5000, 3'b011);
                else expect_fault("R7 int rights", k[1:0], 32'h0800_0000, 32'h3000_5678);
              end
            end
        end

    // stray block response coinciding with walker response
    stray = 1; w_pp = 2; w_rpn = 20'h13579; segs[4] = 32'h0000_0444;
    run(32'h4000_0000, 1, 0, 1, 1, 0);
    expect_res("R3 walk wins over stray block done", 32'h1357_9000, pp_exp(0, 2, 0));
    stray = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule